// File: doc/BRIEF.md
# Dual-Timer Interrupt Flag Controller

This block sits beside a pair of 8-bit down-counting timers and turns their event pulses into CPU interrupt requests. Each timer produces an underflow pulse and a compare-match pulse. The block captures each pulse in a sticky flag. Software clears a flag by writing 1 to its bit. Each flag is masked by its own enable bit. It is then qualified by a 2-bit priority level per timer, which must be strictly above the CPU's current interrupt level.

The two timers can be chained into one 16-bit counter by raising the cascade input. In that mode the chained counter's underflow and compare pulses arrive on dedicated inputs and are steered to the Timer 1 flags only. Timer 0 stops recording events and stops requesting. Its enables stay readable and writable but have no effect. The separate 8-bit Timer 1 pulses are ignored in cascade mode, and the chained-counter pulses are ignored outside it.

Top module: `tmr_irq_ctl`

## Requirements
- R1: A rising event pulse sets its flag at the next clock edge, whatever the enable bits and priority levels are. Flag bit order: 0 = Timer 0 underflow, 1 = Timer 1 underflow, 2 = Timer 0 compare, 3 = Timer 1 compare.
- R2: The flag register is at address 2. Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. Bits 7..4 read as 0.
- R3: If a flag's event arrives in the same cycle as a write-1 clear of that flag, the flag ends set.
- R4: Address 0 holds the compare enables and address 1 holds the underflow enables, with bit 0 for Timer 0 and bit 1 for Timer 1. Both registers are read/write, and bits 7..2 read as 0. Address 3 reads 0.
- R5: Request bit i (same order as the flags) is high exactly when flag i is 1, its enable is 1, and its timer's priority is strictly greater than the CPU level. Priority input bits [1:0] belong to Timer 0 and bits [3:2] to Timer 1.
- R6: A timer whose priority level is 0 never raises a request.
- R7: In cascade mode the Timer 0 flags never set and the Timer 0 requests (bits 0 and 2) stay 0, regardless of the Timer 0 enables.
- R8: In cascade mode the chained-counter underflow sets flag 1 and its compare sets flag 3, and the 8-bit timer event inputs are ignored. Outside cascade mode the chained-counter inputs are ignored.
- R9: Synchronous active-high reset clears all enables and flags, so every request is 0.
- R10: A request is a level. It stays high while its conditions hold and falls as soon as the CPU level rises to or above the timer's priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for both read and write |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Combinational read data at addr_i |
| cascade_i | input | 1 | 1 = timers chained as one 16-bit counter |
| tmr_uf_evt_i | input | 2 | 8-bit timer underflow pulses, bit n = Timer n |
| tmr_cmp_evt_i | input | 2 | 8-bit timer compare pulses, bit n = Timer n |
| wide_uf_evt_i | input | 1 | Chained 16-bit counter underflow pulse |
| wide_cmp_evt_i | input | 1 | Chained 16-bit counter compare pulse |
| tmr_prio_i | input | 4 | Priority per timer, 2 bits each |
| cpu_lvl_i | input | 2 | CPU current interrupt level |
| irq_req_o | output | 4 | Request levels, flag bit order |

## Verification
The assertions assume that the cascade input, the priority levels and the CPU level change only on clock edges. They also assume event inputs are single-cycle pulses sampled at the edge. The bench drives every input one time unit after a rising edge and holds it until the next edge, so each change lands in one known cycle. The bench also keeps the mode steady across each event pulse, so the routing check for each table row sees a single mode.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
    localparam int NUM_TMR  = 2;
    localparam int NUM_KIND = 2;                 // 0 = underflow, 1 = compare
    localparam int NUM_SRC  = NUM_TMR * NUM_KIND;
    localparam int PRIO_W   = 2;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CMP_EN = 2'd0,
        SEL_UF_EN  = 2'd1,
        SEL_FLAGS  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_TMR-1:0] cmp;
        logic [NUM_TMR-1:0] uf;
    } src_vec_t;

    function automatic int src_idx(input int kind, input int tmr);
        return kind * NUM_TMR + tmr;
    endfunction

    function automatic logic level_wins(input logic [PRIO_W-1:0] prio,
                                        input logic [PRIO_W-1:0] lvl);
        return prio > lvl;
    endfunction
endpackage

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
    import tmr_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[i] <= 1'b0;
            else if (set_i[i])
                flag_q[i] <= 1'b1;      // event wins over clear
            else if (clr_i[i])
                flag_q[i] <= 1'b0;
        end

        assert_set_sticks_R1: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flag_q[i]);
        assert_clear_wins_R2: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !flag_q[i]);
        assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
            (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
        assert_race_R3: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && set_i[i]) |=> flag_q[i]);
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs
    import tmr_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic [NUM_SRC-1:0]  flag_i,
    output logic [NUM_SRC-1:0]  en_o,
    output logic [NUM_SRC-1:0]  clr_o,
    output logic [DATA_W-1:0]   rd_data_o
);
    src_vec_t en_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_en_i) begin
            if (sel == SEL_CMP_EN) en_q.cmp <= wr_data_i[NUM_TMR-1:0];
            if (sel == SEL_UF_EN)  en_q.uf  <= wr_data_i[NUM_TMR-1:0];
        end
    end

    assign clr_o = (wr_en_i && sel == SEL_FLAGS) ? wr_data_i[NUM_SRC-1:0] : '0;
    assign en_o  = en_q;

    always_comb begin
        rd_data_o = '0;
        case (sel)
            SEL_CMP_EN: rd_data_o[NUM_TMR-1:0] = en_q.cmp;
            SEL_UF_EN:  rd_data_o[NUM_TMR-1:0] = en_q.uf;
            SEL_FLAGS:  rd_data_o[NUM_SRC-1:0] = flag_i;
            default:    rd_data_o = '0;
        endcase
    end

    assert_cmp_en_write_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && sel == SEL_CMP_EN) |=> en_q.cmp == $past(wr_data_i[NUM_TMR-1:0]));
    assert_uf_en_write_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && sel == SEL_UF_EN) |=> en_q.uf == $past(wr_data_i[NUM_TMR-1:0]));
    assert_en_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(en_q));
    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (en_q == '0));
endmodule

// File: rtl/tmr_irq_gate.sv
module tmr_irq_gate
    import tmr_irq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_SRC-1:0]          flag_i,
    input  logic [NUM_SRC-1:0]          en_i,
    input  logic [NUM_TMR*PRIO_W-1:0]   prio_i,
    input  logic [PRIO_W-1:0]           lvl_i,
    input  logic                        cascade_i,
    output logic [NUM_SRC-1:0]          req_o
);
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        logic [PRIO_W-1:0] prio;
        logic              pass;
        logic              muted;

        assign prio  = prio_i[t*PRIO_W +: PRIO_W];
        assign pass  = level_wins(prio, lvl_i);
        // in cascade only the top timer still reports
        assign muted = cascade_i && (t != NUM_TMR - 1);

        for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
            localparam int S = k * NUM_TMR + t;
            assign req_o[S] = flag_i[S] & en_i[S] & pass & ~muted;

            assert_level_block_R10: assert property (@(posedge clk) disable iff (rst)
                (lvl_i >= prio) |-> !req_o[S]);
            assert_zero_prio_R6: assert property (@(posedge clk) disable iff (rst)
                (prio == '0) |-> !req_o[S]);
            assert_needs_flag_R5: assert property (@(posedge clk) disable iff (rst)
                !flag_i[S] |-> !req_o[S]);
        end
    end
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl
    import tmr_irq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    output logic [DATA_W-1:0]           rd_data_o,
    input  logic                        cascade_i,
    input  logic [NUM_TMR-1:0]          tmr_uf_evt_i,
    input  logic [NUM_TMR-1:0]          tmr_cmp_evt_i,
    input  logic                        wide_uf_evt_i,
    input  logic                        wide_cmp_evt_i,
    input  logic [NUM_TMR*PRIO_W-1:0]   tmr_prio_i,
    input  logic [PRIO_W-1:0]           cpu_lvl_i,
    output logic [NUM_SRC-1:0]          irq_req_o
);
    src_vec_t            set_vec;
    logic [NUM_SRC-1:0]  flags;
    logic [NUM_SRC-1:0]  en;
    logic [NUM_SRC-1:0]  clr;

    // event routing: cascade steers the chained counter to the top timer
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_route
        if (t == NUM_TMR - 1) begin : g_top
            assign set_vec.uf[t]  = cascade_i ? wide_uf_evt_i  : tmr_uf_evt_i[t];
            assign set_vec.cmp[t] = cascade_i ? wide_cmp_evt_i : tmr_cmp_evt_i[t];
        end else begin : g_low
            assign set_vec.uf[t]  = ~cascade_i & tmr_uf_evt_i[t];
            assign set_vec.cmp[t] = ~cascade_i & tmr_cmp_evt_i[t];
        end
    end

    tmr_irq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .flag_i    (flags),
        .en_o      (en),
        .clr_o     (clr),
        .rd_data_o (rd_data_o)
    );

    tmr_irq_flags #(.N(NUM_SRC)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_vec),
        .clr_i  (clr),
        .flag_o (flags)
    );

    tmr_irq_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .flag_i    (flags),
        .en_i      (en),
        .prio_i    (tmr_prio_i),
        .lvl_i     (cpu_lvl_i),
        .cascade_i (cascade_i),
        .req_o     (irq_req_o)
    );

    assert_t0_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (cascade_i && !flags[src_idx(0, 0)] && !flags[src_idx(1, 0)])
            |=> (!flags[src_idx(0, 0)] && !flags[src_idx(1, 0)]));
    assert_t0_no_req_R7: assert property (@(posedge clk) disable iff (rst)
        cascade_i |-> (!irq_req_o[src_idx(0, 0)] && !irq_req_o[src_idx(1, 0)]));
    assert_wide_uf_R8: assert property (@(posedge clk) disable iff (rst)
        (cascade_i && wide_uf_evt_i) |=> flags[src_idx(0, NUM_TMR-1)]);
    assert_wide_cmp_R8: assert property (@(posedge clk) disable iff (rst)
        (cascade_i && wide_cmp_evt_i) |=> flags[src_idx(1, NUM_TMR-1)]);
    assert_flags_reset_R9: assert property (@(posedge clk)
        rst |=> (flags == '0));
endmodule

// File: tb/sim_tmr_irq_ctl.sv
`timescale 1ns/1ps
module sim_tmr_irq_ctl;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       cascade;
    logic [1:0] uf_evt, cmp_evt;
    logic       w_uf, w_cmp;
    logic [3:0] prio;
    logic [1:0] lvl;
    logic [3:0] req;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    tmr_irq_ctl u0 (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .addr_i(addr),
        .wr_data_i(wdata), .rd_data_o(rdata), .cascade_i(cascade),
        .tmr_uf_evt_i(uf_evt), .tmr_cmp_evt_i(cmp_evt),
        .wide_uf_evt_i(w_uf), .wide_cmp_evt_i(w_cmp),
        .tmr_prio_i(prio), .cpu_lvl_i(lvl), .irq_req_o(req)
    );

    // {cascade, evt[5:0] = {w_cmp,w_uf,t1cmp,t0cmp,t1uf,t0uf}, expected flags[3:0]}
    localparam int NVEC = 11;
    localparam logic [10:0] VEC [NVEC] = '{
        11'b0_000001_0001,
        11'b0_000010_0010,
        11'b0_000100_0100,
        11'b0_001000_1000,
        11'b0_111111_1111,
        11'b0_110000_0000,
        11'b1_000101_0000,
        11'b1_010000_0010,
        11'b1_100000_1000,
        11'b1_001010_0000,
        11'b1_111111_1010
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #0.1;
        d = rdata;
    endtask

    task automatic pulse(input logic [5:0] e);
        {w_cmp, w_uf, cmp_evt[1], cmp_evt[0], uf_evt[1], uf_evt[0]} = e;
        tick();
        {w_cmp, w_uf, cmp_evt, uf_evt} = '0;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0; cascade = 1'b0;
        uf_evt = '0; cmp_evt = '0; w_uf = 1'b0; w_cmp = 1'b0;
        prio = '0; lvl = '0;
        tick(); tick();
        rst = 1'b0;

        // R9 reset state
        rd(2'd0, d); check("R9 cmp en", d, 8'h00);
        rd(2'd1, d); check("R9 uf en", d, 8'h00);
        rd(2'd2, d); check("R9 flags", d, 8'h00);
        check("R9 req", {4'h0, req}, 8'h00);

        // R1 R8 table: enables all 0, priority 0
        for (int i = 0; i < NVEC; i++) begin
            wr(2'd2, 8'h0F);
            cascade = VEC[i][10];
            pulse(VEC[i][9:4]);
            cascade = 1'b0;
            rd(2'd2, d);
            check($sformatf("R1 R8 vec %0d", i), d, {4'h0, VEC[i][3:0]});
            check($sformatf("R5 no enable vec %0d", i), {4'h0, req}, 8'h00);
        end

        // R4 enable registers
        wr(2'd0, 8'hFF); rd(2'd0, d); check("R4 cmp en", d, 8'h03);
        wr(2'd1, 8'h02); rd(2'd1, d); check("R4 uf en", d, 8'h02);
        rd(2'd0, d); check("R4 cmp en kept", d, 8'h03);
        rd(2'd3, d); check("R4 unused addr", d, 8'h00);

        // R2 write-1 clear, write-0 no effect
        wr(2'd2, 8'h0F);
        pulse(6'b001111);
        wr(2'd2, 8'h05); rd(2'd2, d); check("R2 w1c", d, 8'h0A);
        wr(2'd2, 8'h00); rd(2'd2, d); check("R2 w0 no effect", d, 8'h0A);

        // R3 event and clear in same cycle
        wr_en = 1'b1; addr = 2'd2; wdata = 8'h02; uf_evt[1] = 1'b1;
        tick();
        wr_en = 1'b0; uf_evt = '0;
        rd(2'd2, d); check("R3 race keeps flag", d, 8'h0A);

        // R5 R10 request levels
        wr(2'd1, 8'h03);
        pulse(6'b001111);
        prio = {2'd1, 2'd2}; lvl = 2'd0;
        #0.1 check("R5 all req", {4'h0, req}, 8'h0F);
        lvl = 2'd1;
        #0.1 check("R10 level equals t1 prio", {4'h0, req}, 8'h05);
        lvl = 2'd2;
        #0.1 check("R10 level blocks all", {4'h0, req}, 8'h00);
        lvl = 2'd0;
        wr(2'd1, 8'h00);
        check("R5 uf disabled", {4'h0, req}, 8'h0C);
        wr(2'd2, 8'h08);
        check("R5 flag cleared", {4'h0, req}, 8'h04);

        // R6 zero priority
        wr(2'd1, 8'h03);
        pulse(6'b001111);
        prio = {2'd0, 2'd3};
        #0.1 check("R6 prio zero", {4'h0, req}, 8'h05);

        // R7 cascade mutes timer 0
        prio = {2'd3, 2'd3};
        cascade = 1'b1;
        #0.1 check("R7 t0 muted", {4'h0, req}, 8'h0A);
        wr(2'd0, 8'h02);
        check("R7 t0 cmp en no effect", {4'h0, req}, 8'h0A);
        wr(2'd0, 8'h03);
        check("R7 t0 cmp en back", {4'h0, req}, 8'h0A);
        cascade = 1'b0;
        #0.1 check("R7 leave cascade", {4'h0, req}, 8'h0F);

        // R9 mid-run reset
        rst = 1'b1; tick(); rst = 1'b0;
        rd(2'd2, d); check("R9 flags after reset", d, 8'h00);
        rd(2'd0, d); check("R9 en after reset", d, 8'h00);
        check("R9 req after reset", {4'h0, req}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule